// File: doc/BRIEF.md
# DMA completion flag register

This block keeps one sticky completion flag for each of sixteen DMA channels. The transfer engine pulses a per-channel completion input. With that pulse it gives two qualifiers: whether the transfer was cut short by a stop request, and whether that transfer was the final one of its sequence. A qualified completion sets the channel's flag. Each flag drives its own interrupt request line, and a combined request line is high while any flag is set.

Software reaches the flags through a byte-wide register port. The low byte address holds channels 7..0 and the next address holds channels 15..8. Software clears a flag by writing 0 to its bit. Writing 1 leaves the bit as it is. For this reason software updates the flags with a read-modify-write: it writes back as 1 the bits it means to keep.

Top module: `dma_done_flags`

## Requirements
- R1: After reset all sixteen flags are 0, `irq_o` is 0, `irq_any_o` is 0 and `rdata_o` is 0.
- R2: A pulse on `done_i[c]` with `stop_i[c]`=0 sets flag c at that clock edge. `irq_o[c]` is 1 from the next cycle on, whatever `last_i[c]` is.
- R3: A pulse on `done_i[c]` with `stop_i[c]`=1 and `last_i[c]`=0 leaves flag c unchanged.
- R4: A pulse on `done_i[c]` with `stop_i[c]`=1 and `last_i[c]`=1 sets flag c.
- R5: A write with `wdata_i` bit b = 0 clears the flag mapped to that bit. A write with bit b = 1 keeps that flag at its value, so a write never sets a flag.
- R6: When a qualified completion and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R7: Address 0x9C maps `wdata_i`/`rdata_o` bits 7..0 to channels 7..0. Address 0x9D maps them to channels 15..8. A write to any other address changes no flag, and a read of any other address returns 0.
- R8: `rdata_o` is registered. In the cycle after an address is presented, it holds that byte of the flags as they stood before that clock edge. Reads change no flag.
- R9: `irq_o` equals the flag vector, and `irq_any_o` is 1 exactly when at least one flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| done_i | input | 16 | Per-channel completion pulse |
| stop_i | input | 16 | Per-channel: transfer ended by a stop request |
| last_i | input | 16 | Per-channel: transfer was the final one |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 16 | Per-channel interrupt request |
| irq_any_o | output | 1 | OR of all channel requests |

## Verification
Every channel receives a completion pulse under all four stop/last combinations. This separates the qualifier cases from one another and also exposes a swapped or stuck channel. All 256 clear masks are written to each byte lane while every flag is set. This shows that a 0 bit clears, a 1 bit keeps, and the lanes do not cross. A write of all ones to empty flags, writes to neighbouring addresses, and a clear that meets a completion in the same cycle cover the remaining cases: no set by write, address decode, and set priority. Read data is compared every cycle against the flags as they stood before that edge.

// File: rtl/dma_done_pkg.sv
package dma_done_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/done_qual.sv
module done_qual #(
  parameter int unsigned N_CH = 16
) (
  input  logic [N_CH-1:0] done_i,
  input  logic [N_CH-1:0] stop_i,
  input  logic [N_CH-1:0] last_i,
  output logic [N_CH-1:0] set_o
);
  // an early stop suppresses the flag; a stop on the final transfer does not
  always_comb set_o = done_i & (~stop_i | last_i);
endmodule

// File: rtl/wr_decode.sv
module wr_decode
  import dma_done_pkg::*;
#(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h9C
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  output logic [N_CH-1:0]   clr_o
);
  localparam int unsigned N_LANE = N_CH / BYTE_W;

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + k);
    logic hit;
    always_comb begin
      hit = we_i && (addr_i == LANE_ADDR);
      clr_o[k*BYTE_W +: BYTE_W] = hit ? ~wdata_i : '0;
    end
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] flags_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[c]) q <= 1'b1;  // set beats clear
      else if (clr_i[c]) q <= 1'b0;
    end
    assign flags_o[c] = q;
  end
endmodule

// File: rtl/rd_port.sv
module rd_port
  import dma_done_pkg::*;
#(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h9C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_CH-1:0]   flags_i,
  output byte_t             rdata_o
);
  localparam int unsigned N_LANE = N_CH / BYTE_W;

  byte_t lane_val [N_LANE];
  byte_t rd_d;

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + k);
    always_comb lane_val[k] = (addr_i == LANE_ADDR) ? flags_i[k*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < N_LANE; k++) rd_d |= lane_val[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end
endmodule

// File: rtl/dma_done_flags.sv
module dma_done_flags
  import dma_done_pkg::*;
#(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h9C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   done_i,
  input  logic [N_CH-1:0]   stop_i,
  input  logic [N_CH-1:0]   last_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_CH-1:0]   irq_o,
  output logic              irq_any_o
);
  logic [N_CH-1:0] set_w, clr_w, flags_w;

  done_qual #(.N_CH(N_CH)) u_qual (
    .done_i(done_i), .stop_i(stop_i), .last_i(last_i), .set_o(set_w)
  );

  wr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wr (
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .clr_o(clr_w)
  );

  flag_bank #(.N_CH(N_CH)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_w), .clr_i(clr_w), .flags_o(flags_w)
  );

  rd_port #(.N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .flags_i(flags_w), .rdata_o(rdata_o)
  );

  assign irq_o     = flags_w;
  assign irq_any_o = |flags_w;
endmodule

// File: rtl/dma_done_flags_chk.sv
module dma_done_flags_chk #(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h9C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CH-1:0]   done_i,
  input logic [N_CH-1:0]   stop_i,
  input logic [N_CH-1:0]   last_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [N_CH-1:0]   irq_o,
  input logic              irq_any_o
);
  localparam int unsigned N_LANE = N_CH / 8;
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);

  logic [N_CH-1:0] qual, clr_mask;
  always_comb begin
    qual = done_i & (~stop_i | last_i);
    clr_mask = '0;
    for (int k = 0; k < N_LANE; k++)
      if (we_i && addr_i == ADDR_W'(BASE_ADDR + k)) clr_mask[k*8 +: 8] = ~wdata_i;
  end

  // R2 R4 R6: a qualified completion always leaves its flag set
  a_r2_qualified_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & $past(qual)) == $past(qual)));

  // R3 R5: a flag rises only through a qualified completion
  a_r3_no_unqualified_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(irq_o) & ~$past(qual)) == '0));

  // R5 R7: a flag falls only under a write-0 to its own lane
  a_r5_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(irq_o) & ~irq_o & ~$past(clr_mask)) == '0));

  // R8: low-lane read returns the flags from before the edge
  a_r8_read_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == LO_ADDR) |=> (rdata_o == $past(irq_o[7:0])));

  // R9: combined request tracks any set flag
  a_r9_any_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_any_o == (irq_o != '0)));
endmodule

bind dma_done_flags dma_done_flags_chk #(
  .N_CH(N_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .stop_i(stop_i), .last_i(last_i),
  .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .irq_any_o(irq_any_o)
);

// File: tb/sim_dma_done_flags.sv
`timescale 1ns/1ps
module sim_dma_done_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] done, stop, last;
  logic        we;
  logic [7:0]  addr, wdata, rdata;
  logic [15:0] irq;
  logic        irq_any;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_flags = '0;

  always #4 clk = ~clk;

  dma_done_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .stop_i(stop), .last_i(last),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .irq_any_o(irq_any)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives one cycle, returns at the next negedge after checking
  task automatic cyc(input logic [15:0] d, input logic [15:0] s, input logic [15:0] l,
                     input logic w, input logic [7:0] a, input logic [7:0] wd,
                     input string tag);
    logic [15:0] set, clr;
    logic [7:0]  exp_rd;
    done = d; stop = s; last = l; we = w; addr = a; wdata = wd;
    exp_rd = (a == 8'h9C) ? exp_flags[7:0] : (a == 8'h9D) ? exp_flags[15:8] : 8'h00;
    set = d & (~s | l);
    clr = '0;
    if (w && a == 8'h9C) clr[7:0]  = ~wd;
    if (w && a == 8'h9D) clr[15:8] = ~wd;
    exp_flags = set | (exp_flags & ~clr);
    @(negedge clk);
    chk({tag, " R9 irq"}, irq, exp_flags);
    chk({tag, " R9 any"}, {15'd0, irq_any}, {15'd0, exp_flags != 0});
    chk({tag, " R8 rdata"}, {8'd0, rdata}, {8'd0, exp_rd});
  endtask

  task automatic idle(input logic [7:0] a);
    cyc('0, '0, '0, 1'b0, a, 8'h00, "idle");
  endtask

  task automatic clear_all();
    cyc('0, '0, '0, 1'b1, 8'h9C, 8'h00, "R5 clr lo");
    cyc('0, '0, '0, 1'b1, 8'h9D, 8'h00, "R5 clr hi");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    done = '0; stop = '0; last = '0; we = 1'b0; addr = 8'h00; wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq", irq, 16'h0);
    chk("R1 any", {15'd0, irq_any}, 16'h0);
    chk("R1 rdata", {8'd0, rdata}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after release", irq, 16'h0);

    // R2 R3 R4: every channel under every stop/last combination
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] bit_c;
        bit_c = 16'h1 << c;
        cyc(bit_c, m[1] ? bit_c : 16'h0, m[0] ? bit_c : 16'h0, 1'b0,
            (c < 8) ? 8'h9C : 8'h9D, 8'h00,
            (m == 2) ? "R3 stop early" : (m == 3) ? "R4 stop last" : "R2 normal");
        idle((c < 8) ? 8'h9C : 8'h9D);
        clear_all();
      end
    end

    // R5: writing ones never sets
    cyc('0, '0, '0, 1'b1, 8'h9C, 8'hFF, "R5 ones lo");
    cyc('0, '0, '0, 1'b1, 8'h9D, 8'hFF, "R5 ones hi");
    chk("R5 ones no set", irq, 16'h0);

    // R5 R7: all clear masks on each lane with every flag set
    for (int ln = 0; ln < 2; ln++) begin
      for (int p = 0; p < 256; p++) begin
        cyc(16'hFFFF, '0, '0, 1'b0, 8'h9C, 8'h00, "R2 set all");
        cyc('0, '0, '0, 1'b1, ln[0] ? 8'h9D : 8'h9C, p[7:0], "R5 R7 mask");
        idle(ln[0] ? 8'h9D : 8'h9C);
      end
    end

    // R6: set beats a clear in the same cycle
    clear_all();
    cyc(16'hFFFF, '0, '0, 1'b0, 8'h9D, 8'h00, "R2 set all");
    cyc(16'h0108, '0, '0, 1'b1, 8'h9C, 8'h00, "R6 set vs clr lo");
    chk("R6 lo", irq, 16'hFF08);
    cyc(16'h0108, 16'h0100, 16'h0100, 1'b1, 8'h9D, 8'h00, "R6 set vs clr hi");
    chk("R6 hi", irq, 16'h0108);

    // R7: neighbouring addresses ignored on write, read as zero
    cyc(16'hFFFF, '0, '0, 1'b0, 8'h9C, 8'h00, "R2 set all");
    cyc('0, '0, '0, 1'b1, 8'h9B, 8'h00, "R7 wr 9B");
    cyc('0, '0, '0, 1'b1, 8'h9E, 8'h00, "R7 wr 9E");
    cyc('0, '0, '0, 1'b1, 8'h1C, 8'h00, "R7 wr 1C");
    idle(8'h9B);
    chk("R7 untouched", irq, 16'hFFFF);
    chk("R7 read other", {8'd0, rdata}, 16'h0);

    // R8: read during a set returns the pre-edge byte
    clear_all();
    cyc(16'h00A5, '0, '0, 1'b0, 8'h9C, 8'h00, "R8 read during set");
    chk("R8 pre-edge", {8'd0, rdata}, 16'h0);
    idle(8'h9C);
    chk("R8 post-edge", {8'd0, rdata}, 16'h00A5);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule